// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block takes a parameterised set of interrupt lines and decides which one the processor should take next. Every line carries a 4-bit urgency code, and a smaller number means more urgent. A programmable grouping value splits that code into two parts. The upper bits form the preemption level, which decides whether a new request may interrupt the handler that is running. The lower bits form a sub-level. The sub-level, and after it the line number, only order requests that are waiting together.

A rising edge on an enabled line marks that line pending. The controller presents one candidate per cycle and flags whether that candidate may nest over the current handler. When the core accepts the candidate, the controller pushes the candidate's preemption level onto an internal stack of active levels. A return strobe pops the stack, so the level that was running before comes back. Software-facing write ports set each line's urgency code, each line's enable, and the grouping value.

Top module: `grpirq_ctrl`

## Requirements
- R1: After reset, the following are all zero: pending lines, active lines, stack depth, presented level, `req_valid_o` and `req_preempt_o`. Also after reset, every urgency code is 0, every enable is 0 and the grouping value is 0.
- R2: A line becomes pending at the clock edge where its input is high, its input was low at the previous edge, and it is enabled. A line that stays high sets nothing more, and an edge on a disabled line sets nothing.
- R3: Among lines that are both pending and enabled, the winner is the one with the smallest 4-bit code. If codes are equal, the lowest line index wins. Because the preemption part occupies the upper bits, this is the same as comparing preemption level first and sub-level second.
- R4: A grouping value g of 0 to 3 gives 4 preemption bits. A value of g from 3 to 7 gives 7-g preemption bits. The preemption level is the code shifted right by the number of sub-level bits, and `level_o` shows the level on top of the stack.
- R5: `req_preempt_o` is high only when a winner exists and either the stack is empty or the winner's preemption level is strictly below the level on top of the stack. Equal levels never nest.
- R6: An accept (`ack_i` while `req_preempt_o` is high and `eret_i` is low) does four things. It clears the presented line's pending bit, unless a new edge on that line arrives in the same cycle. It pushes the line's preemption level. It raises the depth by one. It marks the line active. An `ack_i` that arrives while `req_preempt_o` is low changes nothing.
- R7: `eret_i` pops one stack entry. This restores the previous `level_o` and drops the popped line from `active_o`. An `eret_i` on an empty stack is ignored. In a cycle where both `eret_i` and `ack_i` are high, the pop happens and the accept does not.
- R8: The presented outputs are registered from the state of the previous cycle. In the cycle right after an accept, `req_valid_o` and `req_preempt_o` are low.
- R9: With the reset codes and grouping, once one line is active, no other line can raise `req_preempt_o` until a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NLINES | Interrupt lines, one bit per line; a rising edge requests service |
| prio_we | input | 1 | Write strobe for one line's urgency code |
| prio_idx | input | IW | Line whose urgency code is written |
| prio_wdata | input | PRIO_W | New urgency code |
| en_we | input | 1 | Write strobe for one line's enable |
| en_idx | input | IW | Line whose enable is written |
| en_wdata | input | 1 | New enable value |
| grp_we | input | 1 | Write strobe for the grouping value |
| grp_wdata | input | GRP_W | New grouping value |
| ack_i | input | 1 | Core accepts the presented line |
| eret_i | input | 1 | Handler return: pop the active stack |
| req_valid_o | output | 1 | A pending, enabled line exists |
| req_idx_o | output | IW | Index of the winning line |
| req_preempt_o | output | 1 | The winner may nest over the current level |
| pending_o | output | NLINES | Pending bit of each line |
| active_o | output | NLINES | Lines that currently hold a stack entry |
| depth_o | output | SP_W | Number of stack entries |
| level_o | output | PRIO_W | Preemption level on top of the stack, or 0 when empty |

## Verification
The hardest state to reach from the ports is a completely full stack. Getting there needs sixteen nested handlers whose preemption levels fall strictly from one to the next, and the fill must then be followed by a request at the same level as the top entry. The stimulus sets 4-bit preemption, gives line i the code 15-i, and raises and accepts the lines one after another, so every accept nests one level deeper. The grouping effect is shown by presenting the same pair of codes under two grouping values: the pair nests under one value and not under the other. A long random phase then mixes edges, accepts, returns, simultaneous accept and return, and writes made while requests are in flight. Throughout, a behavioural model built on queues is compared against the outputs every cycle.

// File: rtl/grpirq_ctrl.sv
module grpirq_ctrl #(
  parameter int NLINES = 16,
  parameter int PRIO_W = 4,
  parameter int GRP_W  = 3,
  localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int STK   = 1 << PRIO_W,
  localparam int SP_W  = $clog2(STK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_i,
  input  logic              prio_we,
  input  logic [IW-1:0]     prio_idx,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              en_we,
  input  logic [IW-1:0]     en_idx,
  input  logic              en_wdata,
  input  logic              grp_we,
  input  logic [GRP_W-1:0]  grp_wdata,
  input  logic              ack_i,
  input  logic              eret_i,
  output logic              req_valid_o,
  output logic [IW-1:0]     req_idx_o,
  output logic              req_preempt_o,
  output logic [NLINES-1:0] pending_o,
  output logic [NLINES-1:0] active_o,
  output logic [SP_W-1:0]   depth_o,
  output logic [PRIO_W-1:0] level_o
);
  localparam int GRP_THR = (1 << GRP_W) - 1 - PRIO_W;

  logic [PRIO_W-1:0] prio [NLINES];
  logic [NLINES-1:0] en, pend, irq_q, clr, cand;
  logic [GRP_W-1:0]  grp, sbits;
  logic [PRIO_W-1:0] stk_lvl [STK];
  logic [IW-1:0]     stk_idx [STK];
  logic [SP_W-1:0]   sp, spm1;
  logic              found, win_ok, take, pop;
  logic [IW-1:0]     win;
  logic [PRIO_W-1:0] wprio, wlvl, top, push_lvl;

  assign sbits    = (grp <= GRP_W'(GRP_THR)) ? '0 : grp - GRP_W'(GRP_THR);
  assign cand     = pend & en;
  assign spm1     = sp - 1'b1;
  assign top      = stk_lvl[spm1[PRIO_W-1:0]];
  assign wlvl     = wprio >> sbits;
  assign push_lvl = prio[req_idx_o] >> sbits;
  assign win_ok   = found && ((sp == '0) || (wlvl < top));
  assign take     = ack_i && req_preempt_o && !eret_i;
  assign pop      = eret_i && (sp != '0);
  assign clr      = take ? (NLINES'(1) << req_idx_o) : '0;

  always_comb begin
    found = 1'b0;
    win   = '0;
    wprio = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (cand[i] && (!found || prio[i] < wprio)) begin
        found = 1'b1;
        win   = IW'(i);
        wprio = prio[i];
      end
    end
  end

  always_comb begin
    active_o = '0;
    for (int k = 0; k < STK; k++)
      if (k < int'(sp)) active_o[stk_idx[k]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en            <= '0;
      pend          <= '0;
      irq_q         <= '0;
      grp           <= '0;
      sp            <= '0;
      req_valid_o   <= 1'b0;
      req_idx_o     <= '0;
      req_preempt_o <= 1'b0;
      for (int i = 0; i < NLINES; i++) prio[i] <= '0;
    end else begin
      irq_q         <= irq_i;
      pend          <= (pend & ~clr) | (irq_i & ~irq_q & en);
      req_valid_o   <= found && !take;
      req_idx_o     <= win;
      req_preempt_o <= win_ok && !take;
      if (pop) begin
        sp <= spm1;
      end else if (take && sp < SP_W'(STK)) begin
        stk_lvl[sp[PRIO_W-1:0]] <= push_lvl;
        stk_idx[sp[PRIO_W-1:0]] <= req_idx_o;
        sp <= sp + 1'b1;
      end
      if (prio_we) prio[prio_idx] <= prio_wdata;
      if (en_we)   en[en_idx]     <= en_wdata;
      if (grp_we)  grp            <= grp_wdata;
    end
  end

  assign pending_o = pend;
  assign depth_o   = sp;
  assign level_o   = (sp == '0) ? '0 : top;
endmodule

// File: rtl/grpirq_chk.sv
module grpirq_chk #(
  parameter int NLINES = 16,
  parameter int SP_W   = 5,
  parameter int STK    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic              eret_i,
  input logic              req_valid_o,
  input logic              req_preempt_o,
  input logic [NLINES-1:0] active_o,
  input logic [SP_W-1:0]   depth_o
);
  // R5
  preempt_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_preempt_o |-> req_valid_o);

  // R6
  accept_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_preempt_o && !eret_i) |=> depth_o == $past(depth_o) + 1'b1);

  // R8
  accept_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_preempt_o && !eret_i) |=> (!req_valid_o && !req_preempt_o));

  // R7
  return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && depth_o != '0) |=> depth_o == $past(depth_o) - 1'b1);

  // R7
  empty_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && depth_o == '0) |=> depth_o == '0);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(depth_o) <= STK) && ($countones(active_o) <= int'(depth_o)));
endmodule

bind grpirq_ctrl grpirq_chk #(.NLINES(NLINES), .SP_W(SP_W), .STK(STK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eret_i(eret_i),
  .req_valid_o(req_valid_o), .req_preempt_o(req_preempt_o),
  .active_o(active_o), .depth_o(depth_o)
);

// File: tb/grpirq_ctrl_tb.sv
`timescale 1ns/1ps
module grpirq_ctrl_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic prio_we = 0, en_we = 0, grp_we = 0, en_wdata = 0, ack = 0, eret = 0;
  logic [3:0] prio_idx = '0, en_idx = '0, prio_wdata = '0;
  logic [2:0] grp_wdata = '0;
  logic req_valid, req_preempt;
  logic [3:0] req_idx, level;
  logic [N-1:0] pending, active;
  logic [4:0] depth;

  grpirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
    .en_we(en_we), .en_idx(en_idx), .en_wdata(en_wdata),
    .grp_we(grp_we), .grp_wdata(grp_wdata),
    .ack_i(ack), .eret_i(eret),
    .req_valid_o(req_valid), .req_idx_o(req_idx), .req_preempt_o(req_preempt),
    .pending_o(pending), .active_o(active), .depth_o(depth), .level_o(level)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit [N-1:0] m_pend, m_irqq, m_en;
  int m_prio [N];
  int m_grp, m_ri;
  bit m_rv, m_rp;
  int ql[$], qi[$];

  function automatic int lvl_of(int p, int g);
    return p >> ((g <= 3) ? 0 : g - 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_irqq = '0; m_en = '0; m_grp = 0;
      m_rv = 0; m_rp = 0; m_ri = 0;
      foreach (m_prio[i]) m_prio[i] = 0;
      ql.delete(); qi.delete();
    end else begin
      automatic int best = -1;
      automatic bit tk, pp, nv, np;
      automatic int ni;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_en[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
      tk = ack && m_rp && !eret;
      pp = eret && ql.size() > 0;
      nv = (best >= 0) && !tk;
      ni = (best >= 0) ? best : 0;
      np = (best >= 0) && !tk &&
           (ql.size() == 0 || lvl_of(m_prio[best], m_grp) < ql[ql.size()-1]);
      if (pp) begin
        void'(ql.pop_back()); void'(qi.pop_back());
      end else if (tk) begin
        ql.push_back(lvl_of(m_prio[m_ri], m_grp)); qi.push_back(m_ri);
      end
      if (tk) m_pend[m_ri] = 1'b0;
      m_pend |= irq & ~m_irqq & m_en;
      m_irqq = irq;
      if (prio_we) m_prio[prio_idx] = prio_wdata;
      if (en_we) m_en[en_idx] = en_wdata;
      if (grp_we) m_grp = grp_wdata;
      m_rv = nv; m_rp = np; m_ri = ni;
    end
    #1;
    if (rst_n) begin
      automatic bit [N-1:0] ma = '0;
      foreach (qi[k]) ma[qi[k]] = 1'b1;
      chk("R2 pending", pending, m_pend);
      chk("R8 req_valid", req_valid, m_rv);
      if (m_rv) chk("R3 req_idx", req_idx, m_ri);
      chk("R5 req_preempt", req_preempt, m_rp);
      chk("R6 active", active, ma);
      chk("R7 depth", depth, ql.size());
      chk("R4 level", level, (ql.size() > 0) ? ql[ql.size()-1] : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_prio(int i, int v);
    @(negedge clk); prio_we = 1; prio_idx = 4'(i); prio_wdata = 4'(v);
    @(negedge clk); prio_we = 0;
  endtask

  task automatic set_en(int i, bit v);
    @(negedge clk); en_we = 1; en_idx = 4'(i); en_wdata = v;
    @(negedge clk); en_we = 0;
  endtask

  task automatic set_grp(int g);
    @(negedge clk); grp_we = 1; grp_wdata = 3'(g);
    @(negedge clk); grp_we = 0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic do_ack();
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (req_preempt) begin
        ack = 1; @(negedge clk); ack = 0; return;
      end
    end
  endtask

  task automatic do_eret();
    @(negedge clk); eret = 1; @(negedge clk); eret = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 pending", pending, 0);
    chk("R1 depth", depth, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 level", level, 0);
    @(negedge clk); rst_n = 1;
    cyc(2);

    // R2 edge on disabled line ignored
    pulse(16'h0001); cyc(2);
    chk("R2 disabled edge", pending, 0);

    // R3 tie on equal codes, R9 no nesting at reset codes
    set_en(0, 1); set_en(1, 1);
    pulse(16'h0003); cyc(2);
    chk("R3 tie winner", req_idx, 0);
    chk("R5 empty stack preempt", req_preempt, 1);
    do_ack(); cyc(2);
    chk("R9 valid", req_valid, 1);
    chk("R9 idx", req_idx, 1);
    chk("R9 no nest", req_preempt, 0);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0; cyc(1);
    chk("R6 ignored ack", depth, 1);
    do_eret(); do_ack(); do_eret(); cyc(2);

    // R2 held level sets nothing more
    @(negedge clk); irq[0] = 1; cyc(3);
    do_ack(); cyc(4);
    chk("R2 held high", pending[0], 0);
    @(negedge clk); irq[0] = 0;
    do_eret(); cyc(2);

    // R6/R7 full stack with descending levels
    for (int i = 0; i < N; i++) begin
      set_prio(i, 15 - i); set_en(i, 1);
    end
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i); do_ack();
    end
    cyc(2);
    chk("R6 full depth", depth, 16);
    chk("R4 top level", level, 0);
    pulse(N'(1) << 15); cyc(2);
    chk("R5 equal level", req_preempt, 0);
    for (int i = 0; i < N; i++) do_eret();
    cyc(1);
    chk("R7 drained", depth, 0);
    do_eret(); cyc(1);
    chk("R7 empty return", depth, 0);
    do_ack(); do_eret();

    // R4 grouping decides nesting
    for (int i = 0; i < N; i++) set_en(i, 0);
    set_prio(5, 6); set_prio(3, 4);
    set_grp(3); set_en(5, 1);
    pulse(N'(1) << 5); do_ack();
    set_en(3, 1); pulse(N'(1) << 3); cyc(2);
    chk("R4 four preempt bits nest", req_preempt, 1);
    do_eret(); set_en(3, 0);
    set_grp(5);
    pulse(N'(1) << 5); do_ack();
    set_en(3, 1); cyc(2);
    chk("R4 idx", req_idx, 3);
    chk("R4 two preempt bits no nest", req_preempt, 0);
    do_eret(); cyc(2);

    // random mix
    for (int i = 0; i < N; i++) set_en(i, 1);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      irq = irq ^ (N'($urandom) & N'($urandom) & N'($urandom));
      ack = ($urandom % 3) == 0;
      eret = ($urandom % 5) == 0;
      prio_we = ($urandom % 10) == 0; prio_idx = 4'($urandom); prio_wdata = 4'($urandom);
      en_we = ($urandom % 20) == 0; en_idx = 4'($urandom); en_wdata = ($urandom % 4) != 0;
      grp_we = ($urandom % 100) == 0; grp_wdata = 3'($urandom);
    end
    @(negedge clk);
    ack = 0; eret = 0; prio_we = 0; en_we = 0; grp_we = 0;
    cyc(3);
    finish_run();
  end
endmodule